// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the distribution stage of a multi-core interrupt controller. Software programs it through a simple 32-bit word-addressed register port with byte-lane enables. Up to `NUM_LINES` interrupt lines are held here, each with an enable bit, a trigger mode, an 8-bit priority and a CPU routing byte. For each of `NUM_CPUS` processors the block presents the single most urgent line that is pending, enabled and routed to that processor.

Lines fall into three fixed ranges. Lines 0 to 15 are software lines: they have no hardware input and become pending per CPU only through a write to the software-trigger register. Lines 16 to 31 are private lines: they have hardware inputs and fixed routing to every CPU. Lines 32 and above are shared lines with programmable routing and trigger mode. A processor that takes the presented line pulses its accept input, which retires the pending state of an edge or software line.

The register port carries a word address, that is the byte offset divided by four. Byte offsets below are given for reference: control 0x000, type 0x004, set-enable 0x100, clear-enable 0x180, priority 0x400, routing 0x800, trigger configuration 0xC00, software trigger 0xF00. Reads are combinational from `reg_word`. Unmapped words, and the software-trigger word, read as zero.

Top module: `irq_dist_bank`

## Requirements
- R1: Bit 0 of the control word (byte offset 0x000) gates all presentation. While it is 0, every `cpu_valid` bit is 0 from the next cycle on. Pending state is kept and reappears once the bit is set again.
- R2: The type word (0x004) is read-only and reads `NUM_LINES/32 - 1` in bits [4:0] (value 1 for 64 lines). Writes to it have no effect.
- R3: Enables are held in words of 32 lines: word line/32, bit line%32. Writing a 1 to the set bank (0x100) enables the line, and writing a 1 to the clear bank (0x180) disables it. A 0 bit leaves the enable unchanged. Both banks read back the current enables. A disabled line is never presented.
- R4: Priority is one byte per line, four lines per word from 0x400, with line%4 selecting byte lane 8*(line%4). Only lanes whose `reg_be` bit is set are written.
- R5: Routing is one byte per line, four lines per word from 0x800. For lines 32 and above, bit c routes the line to CPU c. Single-lane writes change only that line.
- R6: Configuration is two bits per line, sixteen lines per word from 0xC00, at bits 2*(line%16). Bit 1 set selects edge mode, and clear selects level mode. For lines below 32, routing and configuration ignore writes: routing reads as the mask of all CPUs (0x0F for four CPUs), software lines read configuration 2'b10 and private lines read 2'b00.
- R7: A level-mode line is pending exactly while its input is high. An accept has no effect on it.
- R8: An edge-mode line becomes pending on a rising input edge and stays pending until an accept of that line. When a rising edge and an accept of the same line fall in the same cycle, the line stays pending.
- R9: A write to the software-trigger word (0xF00) makes line `wdata[3:0]` pending for each CPU c with `wdata[16+c]` set. Each CPU's copy is cleared only by that CPU's accept. A trigger and an accept of the same line by the same CPU in the same cycle leave it pending.
- R10: Among candidate lines, a CPU is given the one with the lowest priority value, and on equal priority the lowest line number.
- R11: Presentation is registered. A change of pending state, enable, priority, routing or control reaches `cpu_valid`/`cpu_id` one clock after it takes effect. After reset all enables, priorities and the control bit are 0, shared lines route to CPU 0 in level mode, and no CPU output is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 10 | Word address (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data for `reg_word` |
| irq_in | input | NUM_LINES-16 | Hardware inputs of lines 16 and above (bit index = line) |
| cpu_accept | input | NUM_CPUS | Per-CPU accept of the presented line |
| cpu_valid | output | NUM_CPUS | Per-CPU line presented |
| cpu_id | output | NUM_CPUS*6 | Per-CPU presented line number, 6 bits per CPU |

## Verification
Setting pending state and retiring it can hit the same line in one cycle. The bench provokes this in two ways. First, an edge line is held pending with its input low, and then a new rising edge is driven in the same cycle as the CPU accepts it. Second, a software trigger to a CPU is written in the same cycle as that CPU's accept of the same software line. In both cases the line must still be presented two cycles later, and one further accept with no new event must then retire it.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int SOFT_N   = 16;   // software lines 0..15
    localparam int PRIV_END = 32;   // first shared line
    localparam int PRIO_W   = 8;

    // word addresses (byte offset >> 2)
    localparam logic [9:0] W_CTL   = 10'h000;
    localparam logic [9:0] W_TYPE  = 10'h001;
    localparam logic [9:0] W_SETEN = 10'h040;
    localparam logic [9:0] W_CLREN = 10'h060;
    localparam logic [9:0] W_PRIO  = 10'h100;
    localparam logic [9:0] W_TGT   = 10'h200;
    localparam logic [9:0] W_CFG   = 10'h300;
    localparam logic [9:0] W_SOFT  = 10'h3C0;

    localparam logic [1:0] CFG_SOFT = 2'b10;
    localparam logic [1:0] CFG_PRIV = 2'b00;

endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [9:0]                    reg_word,
    input  logic [31:0]                   reg_wdata,
    input  logic [3:0]                    reg_be,
    output logic [31:0]                   reg_rdata,
    output logic                          dist_on,
    output logic [NUM_LINES-1:0]          en_vec,
    output logic [NUM_LINES*PRIO_W-1:0]   prio_flat,
    output logic [NUM_LINES*NUM_CPUS-1:0] tgt_flat,
    output logic [NUM_LINES-1:SOFT_N]     edge_vec,
    output logic                          soft_wr,
    output logic [3:0]                    soft_id,
    output logic [NUM_CPUS-1:0]           soft_tgt
);

    localparam int NW = NUM_LINES / 32;
    localparam logic [7:0] ALL_CPU = 8'((1 << NUM_CPUS) - 1);

    typedef struct packed {
        logic                                ctl;
        logic [NUM_LINES-1:0]                en;
        logic [NUM_LINES-1:0][PRIO_W-1:0]    prio;
        logic [NUM_LINES-1:0][7:0]           tgt;
        logic [NUM_LINES-1:0][1:0]           cfg;
    } regs_t;

    regs_t s_q, s_d;
    logic [31:0] wmask;

    function automatic regs_t reset_val();
        regs_t r;
        r.ctl = 1'b0;
        r.en  = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            r.prio[l] = '0;
            r.tgt[l]  = (l < PRIV_END) ? ALL_CPU : 8'h01;
            r.cfg[l]  = (l < SOFT_N) ? CFG_SOFT : CFG_PRIV;
        end
        return r;
    endfunction

    always_comb begin
        for (int b = 0; b < 4; b++) wmask[8*b +: 8] = {8{reg_be[b]}};
    end

    // next-state: register writes
    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            if (reg_word == W_CTL && reg_be[0]) s_d.ctl = reg_wdata[0];   // R1
            for (int l = 0; l < NUM_LINES; l++) begin
                // R3: write-one-to-set / write-one-to-clear
                if (reg_word == W_SETEN + 10'(l / 32) && wmask[l % 32] && reg_wdata[l % 32])
                    s_d.en[l] = 1'b1;
                if (reg_word == W_CLREN + 10'(l / 32) && wmask[l % 32] && reg_wdata[l % 32])
                    s_d.en[l] = 1'b0;
                // R4
                if (reg_word == W_PRIO + 10'(l / 4) && reg_be[l % 4])
                    s_d.prio[l] = reg_wdata[8*(l % 4) +: 8];
                // R5, R6: only shared lines are writable here
                if (l >= PRIV_END) begin
                    if (reg_word == W_TGT + 10'(l / 4) && reg_be[l % 4])
                        s_d.tgt[l] = reg_wdata[8*(l % 4) +: 8];
                    if (reg_word == W_CFG + 10'(l / 16) && reg_be[(l % 16) / 4])
                        s_d.cfg[l] = reg_wdata[2*(l % 16) +: 2];
                end
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_word == W_CTL)  reg_rdata[0]   = s_q.ctl;
        if (reg_word == W_TYPE) reg_rdata[4:0] = 5'(NW - 1);   // R2
        for (int l = 0; l < NUM_LINES; l++) begin
            if (reg_word == W_SETEN + 10'(l / 32) || reg_word == W_CLREN + 10'(l / 32))
                reg_rdata[l % 32] = s_q.en[l];
            if (reg_word == W_PRIO + 10'(l / 4))
                reg_rdata[8*(l % 4) +: 8] = s_q.prio[l];
            if (reg_word == W_TGT + 10'(l / 4))
                reg_rdata[8*(l % 4) +: 8] = s_q.tgt[l];
            if (reg_word == W_CFG + 10'(l / 16))
                reg_rdata[2*(l % 16) +: 2] = s_q.cfg[l];
        end
    end

    always_comb begin
        dist_on = s_q.ctl;
        en_vec  = s_q.en;
        for (int l = 0; l < NUM_LINES; l++) begin
            prio_flat[PRIO_W*l +: PRIO_W]  = s_q.prio[l];
            tgt_flat[NUM_CPUS*l +: NUM_CPUS] = s_q.tgt[l][NUM_CPUS-1:0];
        end
        for (int l = SOFT_N; l < NUM_LINES; l++) edge_vec[l] = s_q.cfg[l][1];
        soft_wr  = reg_wr && (reg_word == W_SOFT);          // R9
        soft_id  = reg_wdata[3:0];
        soft_tgt = reg_wdata[16 +: NUM_CPUS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_val();
        else        s_q <= s_d;
    end

endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:SOFT_N]   irq_in,
    input  logic [NUM_LINES-1:SOFT_N]   edge_vec,
    input  logic                        soft_wr,
    input  logic [3:0]                  soft_id,
    input  logic [NUM_CPUS-1:0]         soft_tgt,
    input  logic [NUM_CPUS-1:0]         clr_req,
    input  logic [NUM_CPUS*ID_W-1:0]    clr_id,
    output logic [NUM_LINES-1:SOFT_N]   line_pend,
    output logic [SOFT_N*NUM_CPUS-1:0]  soft_pend
);

    typedef struct packed {
        logic [NUM_LINES-1:SOFT_N]           prev;
        logic [NUM_LINES-1:SOFT_N]           lat;
        logic [SOFT_N-1:0][NUM_CPUS-1:0]     sp;
    } pend_t;

    pend_t s_q, s_d;

    always_comb begin
        logic clr;
        logic rise;
        logic set;
        s_d      = s_q;
        s_d.prev = irq_in;
        // R8: edge latch, new edge wins over a same-cycle accept
        for (int l = SOFT_N; l < NUM_LINES; l++) begin
            clr = 1'b0;
            for (int c = 0; c < NUM_CPUS; c++)
                if (clr_req[c] && clr_id[c*ID_W +: ID_W] == ID_W'(l)) clr = 1'b1;
            rise = irq_in[l] & ~s_q.prev[l];
            s_d.lat[l] = edge_vec[l] & (rise | (s_q.lat[l] & ~clr));
        end
        // R9: per-CPU software pending, trigger wins over accept
        for (int l = 0; l < SOFT_N; l++) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                set = soft_wr && (soft_id == 4'(l)) && soft_tgt[c];
                clr = clr_req[c] && (clr_id[c*ID_W +: ID_W] == ID_W'(l));
                s_d.sp[l][c] = set | (s_q.sp[l][c] & ~clr);
            end
        end
    end

    always_comb begin
        // R7: level lines follow the input
        for (int l = SOFT_N; l < NUM_LINES; l++)
            line_pend[l] = edge_vec[l] ? s_q.lat[l] : irq_in[l];
        for (int l = 0; l < SOFT_N; l++)
            for (int c = 0; c < NUM_CPUS; c++)
                soft_pend[l*NUM_CPUS + c] = s_q.sp[l][c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dist_on,
    input  logic [NUM_LINES-1:0]          en_vec,
    input  logic [NUM_LINES*PRIO_W-1:0]   prio_flat,
    input  logic [NUM_LINES-1:0]          req,
    output logic                          out_valid,
    output logic [ID_W-1:0]               out_id
);

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } sel_t;

    sel_t s_q, s_d;

    // R10: strict less-than in ascending order keeps the lower line on a tie
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        best_p  = '1;
        s_d     = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (dist_on && en_vec[l] && req[l] &&
                (!s_d.valid || prio_flat[PRIO_W*l +: PRIO_W] < best_p)) begin
                s_d.valid = 1'b1;
                s_d.id    = ID_W'(l);
                best_p    = prio_flat[PRIO_W*l +: PRIO_W];
            end
        end
    end

    // R11: registered presentation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_id    = s_q.id;

endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reg_wr,
    input  logic [9:0]                              reg_word,
    input  logic [31:0]                             reg_wdata,
    input  logic [3:0]                              reg_be,
    output logic [31:0]                             reg_rdata,
    input  logic [NUM_LINES-1:SOFT_N]               irq_in,
    input  logic [NUM_CPUS-1:0]                     cpu_accept,
    output logic [NUM_CPUS-1:0]                     cpu_valid,
    output logic [NUM_CPUS*$clog2(NUM_LINES)-1:0]   cpu_id
);

    localparam int ID_W = $clog2(NUM_LINES);

    logic                          dist_on;
    logic [NUM_LINES-1:0]          en_vec;
    logic [NUM_LINES*PRIO_W-1:0]   prio_flat;
    logic [NUM_LINES*NUM_CPUS-1:0] tgt_flat;
    logic [NUM_LINES-1:SOFT_N]     edge_vec;
    logic                          soft_wr;
    logic [3:0]                    soft_id;
    logic [NUM_CPUS-1:0]           soft_tgt;
    logic [NUM_LINES-1:SOFT_N]     line_pend;
    logic [SOFT_N*NUM_CPUS-1:0]    soft_pend;
    logic [NUM_CPUS-1:0]           clr_req;

    assign clr_req = cpu_accept & cpu_valid;

    irq_dist_regs #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_word  (reg_word),
        .reg_wdata (reg_wdata),
        .reg_be    (reg_be),
        .reg_rdata (reg_rdata),
        .dist_on   (dist_on),
        .en_vec    (en_vec),
        .prio_flat (prio_flat),
        .tgt_flat  (tgt_flat),
        .edge_vec  (edge_vec),
        .soft_wr   (soft_wr),
        .soft_id   (soft_id),
        .soft_tgt  (soft_tgt)
    );

    irq_dist_pend #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .edge_vec  (edge_vec),
        .soft_wr   (soft_wr),
        .soft_id   (soft_id),
        .soft_tgt  (soft_tgt),
        .clr_req   (clr_req),
        .clr_id    (cpu_id),
        .line_pend (line_pend),
        .soft_pend (soft_pend)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [NUM_LINES-1:0] req;
        always_comb begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (l < SOFT_N)
                    req[l] = soft_pend[l*NUM_CPUS + c] & tgt_flat[l*NUM_CPUS + c];
                else
                    req[l] = line_pend[l] & tgt_flat[l*NUM_CPUS + c];
            end
        end

        irq_dist_arb #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .dist_on   (dist_on),
            .en_vec    (en_vec),
            .prio_flat (prio_flat),
            .req       (req),
            .out_valid (cpu_valid[c]),
            .out_id    (cpu_id[c*ID_W +: ID_W])
        );
    end

endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
    import irq_dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [9:0]                   reg_word,
    input logic [31:0]                  reg_rdata,
    input logic                         dist_on,
    input logic [NUM_LINES-1:0]         en_vec,
    input logic [PRIV_END*NUM_CPUS-1:0] tgt_low,
    input logic [SOFT_N*NUM_CPUS-1:0]   soft_pend,
    input logic [NUM_CPUS-1:0]          clr_req,
    input logic [NUM_CPUS-1:0]          cpu_valid
);

    localparam int NW = NUM_LINES / 32;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_on |=> (cpu_valid == '0)); // R1

    AST_TYPE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word == W_TYPE) |-> (reg_rdata == 32'(NW - 1))); // R2

    AST_CLR_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word >= W_CLREN && reg_word < W_CLREN + 10'(NW))
        |=> ((en_vec & ~$past(en_vec)) == '0)); // R3

    AST_SET_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word >= W_SETEN && reg_word < W_SETEN + 10'(NW))
        |=> ((~en_vec & $past(en_vec)) == '0)); // R3

    AST_LOW_RO: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(tgt_low)); // R6

    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req == '0) |=> ((soft_pend & $past(soft_pend)) == $past(soft_pend))); // R9

endmodule

bind irq_dist_bank irq_dist_chk #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .reg_rdata (reg_rdata),
    .dist_on   (dist_on),
    .en_vec    (en_vec),
    .tgt_low   (tgt_flat[32*NUM_CPUS-1:0]),
    .soft_pend (soft_pend),
    .clr_req   (clr_req),
    .cpu_valid (cpu_valid)
);

// File: tb/irq_dist_bank_bench.sv
module irq_dist_bank_bench;

    localparam int L    = 64;
    localparam int C    = 4;
    localparam int ID_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [9:0]        reg_word = '0;
    logic [31:0]       reg_wdata = '0;
    logic [3:0]        reg_be = '0;
    logic [31:0]       reg_rdata;
    logic [L-1:16]     irq_in = '0;
    logic [C-1:0]      cpu_accept = '0;
    logic [C-1:0]      cpu_valid;
    logic [C*ID_W-1:0] cpu_id;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_dist_bank #(.NUM_LINES(L), .NUM_CPUS(C)) u_irq_dist_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_word   (reg_word),
        .reg_wdata  (reg_wdata),
        .reg_be     (reg_be),
        .reg_rdata  (reg_rdata),
        .irq_in     (irq_in),
        .cpu_accept (cpu_accept),
        .cpu_valid  (cpu_valid),
        .cpu_id     (cpu_id)
    );

    typedef struct packed {
        logic [9:0]  w;
        logic [31:0] d;
        logic [3:0]  be;
        logic [31:0] r;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{10'h000, 32'h0000_0001, 4'hF, 32'h0000_0001},   // R1 control on
        '{10'h040, 32'h0001_0003, 4'hF, 32'h0001_0003},   // R3 set lines 0,1,16
        '{10'h060, 32'h0000_0001, 4'hF, 32'h0001_0002},   // R3 clear line 0
        '{10'h040, 32'h0000_0000, 4'hF, 32'h0001_0002},   // R3 zeros ignored
        '{10'h108, 32'h4030_2010, 4'hF, 32'h4030_2010},   // R4 lines 32..35
        '{10'h108, 32'h0000_AA00, 4'h2, 32'h4030_AA10},   // R4 single lane
        '{10'h208, 32'h0804_0201, 4'hF, 32'h0804_0201},   // R5 routing 32..35
        '{10'h208, 32'h0000_0300, 4'h2, 32'h0804_0301},   // R5 single lane
        '{10'h200, 32'hFFFF_FFFF, 4'hF, 32'h0F0F_0F0F},   // R6 low routing read-only
        '{10'h300, 32'h0000_0000, 4'hF, 32'hAAAA_AAAA},   // R6 software cfg fixed
        '{10'h301, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000},   // R6 private cfg fixed
        '{10'h302, 32'h0000_0002, 4'hF, 32'h0000_0002},   // R6 line 32 edge
        '{10'h001, 32'hFFFF_FFFF, 4'hF, 32'h0000_0001}    // R2 type read-only
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] w, input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1'b1; reg_word = w; reg_wdata = d; reg_be = be;
        tick();
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [9:0] w, input logic [31:0] exp, input string tag);
        reg_word = w;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic cpu(input int c, input logic v, input int id, input string tag);
        logic [31:0] act, exp;
        act = cpu_valid[c] ? {25'd0, 1'b1, cpu_id[c*ID_W +: ID_W]} : 32'd0;
        exp = v ? {25'd0, 1'b1, 6'(id)} : 32'd0;
        chk(tag, act, exp);
    endtask

    task automatic accept(input int c);
        cpu_accept[c] = 1'b1;
        tick();
        cpu_accept[c] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        rd(10'h000, 32'h0, "R11 ctl reset");
        rd(10'h001, 32'h1, "R2 type reset");
        rd(10'h040, 32'h0, "R11 enables reset");
        rd(10'h300, 32'hAAAA_AAAA, "R6 sw cfg reset");
        rd(10'h301, 32'h0, "R6 private cfg reset");
        rd(10'h208, 32'h0101_0101, "R11 shared routing reset");
        rd(10'h204, 32'h0F0F_0F0F, "R6 private routing reset");
        rd(10'h100, 32'h0, "R11 prio reset");
        chk("R11 no valid after reset", 32'(cpu_valid), 32'h0);

        // table: write then read back
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].w, VECS[i].d, VECS[i].be);
            rd(VECS[i].w, VECS[i].r, $sformatf("table vector %0d", i));
        end

        // enable 32..35 with nothing pending
        wr(10'h041, 32'hF, 4'hF); tick();
        chk("R10 enabled but idle", 32'(cpu_valid), 32'h0);

        // R7 level line 34 -> CPU2
        irq_in[34] = 1'b1; tick();
        cpu(2, 1'b1, 34, "R7 level presented");
        cpu(0, 1'b0, 0,  "R5 not routed to cpu0");

        // R5 retarget 35 to CPU2, R10 priority
        irq_in[35] = 1'b1;
        wr(10'h208, 32'h0400_0000, 4'h8); tick();
        cpu(2, 1'b1, 34, "R10 lower value wins");
        cpu(3, 1'b0, 0,  "R5 retarget leaves cpu3");
        wr(10'h108, 32'h3000_0000, 4'h8); tick();
        cpu(2, 1'b1, 34, "R10 tie lower line");
        wr(10'h108, 32'h2000_0000, 4'h8); tick();
        cpu(2, 1'b1, 35, "R4 R10 new priority wins");

        // R7 accept on level line has no effect
        accept(2); tick();
        cpu(2, 1'b1, 35, "R7 accept ignored on level");
        irq_in[34] = 1'b0; irq_in[35] = 1'b0; tick();
        cpu(2, 1'b0, 0, "R7 level drop");

        // R8 edge line 32 -> CPU0, R11 latency
        irq_in[32] = 1'b1; tick();
        cpu(0, 1'b0, 0, "R11 one-cycle latency");
        tick();
        cpu(0, 1'b1, 32, "R8 edge presented");
        accept(0); tick();
        cpu(0, 1'b0, 0, "R8 accept clears, input high");

        // R8 edge and accept in the same cycle
        irq_in[32] = 1'b0; tick();
        irq_in[32] = 1'b1; tick(); tick();
        cpu(0, 1'b1, 32, "R8 second edge");
        irq_in[32] = 1'b0; tick();
        irq_in[32] = 1'b1; accept(0); tick();
        cpu(0, 1'b1, 32, "R8 edge beats accept");
        accept(0); tick();
        cpu(0, 1'b0, 0, "R8 later accept clears");

        // R9 software trigger line 1 to CPU1 and CPU3
        wr(10'h3C0, 32'h000A_0001, 4'hF); tick();
        cpu(1, 1'b1, 1, "R9 sw cpu1");
        cpu(3, 1'b1, 1, "R9 sw cpu3");
        cpu(0, 1'b0, 0, "R9 sw not cpu0");
        accept(1); tick();
        cpu(1, 1'b0, 0, "R9 cpu1 copy cleared");
        cpu(3, 1'b1, 1, "R9 cpu3 copy kept");

        // R9 trigger and accept same cycle
        cpu_accept[3] = 1'b1;
        wr(10'h3C0, 32'h0008_0001, 4'hF);
        cpu_accept[3] = 1'b0; tick();
        cpu(3, 1'b1, 1, "R9 trigger beats accept");
        accept(3); tick();
        cpu(3, 1'b0, 0, "R9 later accept clears");

        // R6 private line 16 to all CPUs, R10 tie with line 1
        irq_in[16] = 1'b1;
        wr(10'h3C0, 32'h0008_0001, 4'hF); tick();
        cpu(0, 1'b1, 16, "R6 private routed cpu0");
        cpu(3, 1'b1, 1,  "R10 tie line 1 over 16");

        // R1 gate
        wr(10'h000, 32'h0, 4'hF); tick();
        chk("R1 gate off", 32'(cpu_valid), 32'h0);
        wr(10'h000, 32'h1, 4'hF); tick();
        cpu(0, 1'b1, 16, "R1 gate on restores");

        // R3 disable and held pending
        wr(10'h060, 32'h0001_0000, 4'hF); tick();
        cpu(0, 1'b0, 0, "R3 disabled not presented");
        wr(10'h3C0, 32'h0001_0002, 4'hF); tick();
        cpu(0, 1'b0, 0, "R3 sw to disabled line");
        wr(10'h040, 32'h0000_0004, 4'hF); tick();
        cpu(0, 1'b1, 2, "R3 enable reveals pending");

        finish_run();
    end

endmodule